// File: doc/BRIEF.md
# Effective Address Sequencer

This block resolves the operand of a two-word instruction for a small accumulator processor. Memory holds 16-bit words with one address per word, and the address space is 16 bits. When a new instruction starts, the block is given the address of its opcode word, the opcode word itself, and the two index registers. It reads the operand word that follows the opcode. Depending on the addressing mode in the opcode, it may then read a pointer word. It reports the final effective address, or the immediate value, with a one-cycle done pulse.

There is no zero page, so any pointer can sit anywhere in the 16-bit space. Besides the usual absolute, indexed and indirect forms, the block supports a double-indexed mode. This mode adds X to the operand, reads a pointer at that location, and then adds Y to the pointer. The block reads memory through a synchronous single-port read interface that can stall. It reports the program counter advance as a fixed increment.

Top module: `amode_seq`

## Requirements
- R1: During and right after synchronous reset, `done`, `mem_rd` and `is_imm` are low.
- R2: The first read of every instruction is at `pc_in + 1`, wrapping modulo 2^16.
- R3: The mode is `opcode[2:0]`: 0 immediate, 1 absolute, 2 absolute+X, 3 absolute+Y, 4 indirect, 5 X-pre-indexed indirect, 6 Y-post-indexed indirect, 7 X-then-Y indirect. In mode 0 the result is the operand word, `is_imm` is high with `done`, and only one read is made.
- R4: In modes 1, 2 and 3 the result is the operand plus 0, X or Y respectively, modulo 2^16. Only one read is made, and `is_imm` is low.
- R5: In modes 4 and 5 a second read is made at the operand plus 0 or X respectively, modulo 2^16. The word read there is the result.
- R6: In mode 6 the second read is at the operand, and the result is that word plus Y, modulo 2^16.
- R7: In mode 7 the second read is at the operand plus X, and the result is that word plus Y, both modulo 2^16.
- R8: A read is accepted on a clock edge where `mem_rd` is high and `mem_wait` is low. While `mem_wait` holds it off, `mem_rd` and `mem_addr` stay unchanged. The read data is taken from `mem_rdata` one cycle after acceptance.
- R9: `done` is high for exactly one cycle per instruction. With `mem_wait` held low, counting the edge that takes `start` as the first, `done` rises on the third edge in modes 0 to 3 and on the fifth edge in modes 4 to 7.
- R10: `pc_inc` reads 2 whenever `done` is high.
- R11: `start` is ignored while an instruction is in progress. It changes neither the result nor the number of done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving a new instruction |
| pc_in | input | 16 | Address of the opcode word |
| opcode | input | 16 | Opcode word; bits 2:0 select the mode |
| idx_x | input | 16 | X index register |
| idx_y | input | 16 | Y index register |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read request |
| mem_rdata | input | 16 | Read data, valid one cycle after acceptance |
| mem_wait | input | 1 | Stall for the pending read |
| done | output | 1 | One-cycle result strobe |
| result | output | 16 | Effective address or immediate value |
| is_imm | output | 1 | Result is immediate data (valid with done) |
| pc_inc | output | 3 | Program counter advance (valid with done) |

## Verification
The bench builds the block with its default 16-bit word, a mode field at bit 0 and a 3-bit increment output. It backs the block with a memory whose contents are a computed hash of the address, so every pointer is known without storing a table. All eight modes are swept across index and program counter values that include all-ones. This brings wrap-around of both the operand fetch and the index additions within reach. Each mode is run once with no stalls, to pin down the exact latency, and once with pseudo-random stalls. A restart during a busy instruction is also covered.

// File: rtl/amode_pkg.sv
package amode_pkg;
  typedef enum logic [2:0] {
    AM_IMM   = 3'd0,
    AM_ABS   = 3'd1,
    AM_ABSX  = 3'd2,
    AM_ABSY  = 3'd3,
    AM_IND   = 3'd4,
    AM_INDX  = 3'd5,
    AM_INDY  = 3'd6,
    AM_INDXY = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OPRQ  = 3'd1,
    ST_OPDAT = 3'd2,
    ST_PTRQ  = 3'd3,
    ST_PTDAT = 3'd4
  } aseq_st_e;

  function automatic logic is_indirect(amode_e m);
    return m[2];
  endfunction
endpackage

// File: rtl/amode_wrap_add.sv
module amode_wrap_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  // carry out of the top bit is dropped: arithmetic wraps modulo 2^W
  assign sum = a + b;
endmodule

// File: rtl/amode_idx_pick.sv
module amode_idx_pick
  import amode_pkg::*;
#(
  parameter int W = 16
) (
  input  amode_e       mode,
  input  logic         post,   // 0: operand phase, 1: pointer phase
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    if (!post) begin
      unique case (mode)
        AM_ABSX, AM_INDX, AM_INDXY: idx = x;
        AM_ABSY:                    idx = y;
        default:                    idx = '0;
      endcase
    end else begin
      unique case (mode)
        AM_INDY, AM_INDXY: idx = y;
        default:           idx = '0;
      endcase
    end
  end
endmodule

// File: rtl/amode_seq.sv
module amode_seq
  import amode_pkg::*;
#(
  parameter int W        = 16,
  parameter int MODE_LSB = 0,
  parameter int INCW     = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [W-1:0]    pc_in,
  input  logic [W-1:0]    opcode,
  input  logic [W-1:0]    idx_x,
  input  logic [W-1:0]    idx_y,
  output logic [W-1:0]    mem_addr,
  output logic            mem_rd,
  input  logic [W-1:0]    mem_rdata,
  input  logic            mem_wait,
  output logic            done,
  output logic [W-1:0]    result,
  output logic            is_imm,
  output logic [INCW-1:0] pc_inc
);
  localparam int          MODE_W   = 3;
  localparam logic [W-1:0] ONE     = W'(1);
  localparam logic [INCW-1:0] WORDS = INCW'(2);

  aseq_st_e     st;
  amode_e       mode_q;
  logic [W-1:0] x_q, y_q;
  logic [W-1:0] idx, sum, pc_next;
  logic         accept;

  assign accept = mem_rd && !mem_wait;

  amode_idx_pick #(.W(W)) u_pick (
    .mode (mode_q),
    .post (st == ST_PTDAT),
    .x    (x_q),
    .y    (y_q),
    .idx  (idx)
  );

  // one adder serves both phases: the base is always the word just read
  amode_wrap_add #(.W(W)) u_sum (
    .a   (mem_rdata),
    .b   (idx),
    .sum (sum)
  );

  amode_wrap_add #(.W(W)) u_pcadd (
    .a   (pc_in),
    .b   (ONE),
    .sum (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mode_q   <= AM_IMM;
      x_q      <= '0;
      y_q      <= '0;
      mem_addr <= '0;
      mem_rd   <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      is_imm   <= 1'b0;
      pc_inc   <= '0;
    end else begin
      done   <= 1'b0;
      is_imm <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            mode_q   <= amode_e'(opcode[MODE_LSB +: MODE_W]);
            x_q      <= idx_x;
            y_q      <= idx_y;
            mem_addr <= pc_next;
            mem_rd   <= 1'b1;
            st       <= ST_OPRQ;
          end
        end
        ST_OPRQ, ST_PTRQ: begin
          if (accept) begin
            mem_rd <= 1'b0;
            st     <= (st == ST_OPRQ) ? ST_OPDAT : ST_PTDAT;
          end
        end
        ST_OPDAT: begin
          if (is_indirect(mode_q)) begin
            mem_addr <= sum;
            mem_rd   <= 1'b1;
            st       <= ST_PTRQ;
          end else begin
            result <= sum;
            is_imm <= (mode_q == AM_IMM);
            done   <= 1'b1;
            pc_inc <= WORDS;
            st     <= ST_IDLE;
          end
        end
        ST_PTDAT: begin
          result <= sum;
          done   <= 1'b1;
          pc_inc <= WORDS;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amode_seq_chk.sv
module amode_seq_chk #(
  parameter int W    = 16,
  parameter int INCW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [W-1:0]    mem_addr,
  input logic            mem_rd,
  input logic            mem_wait,
  input logic            done,
  input logic            is_imm,
  input logic [INCW-1:0] pc_inc
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!done && !mem_rd && !is_imm));

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_wait) |=> (mem_rd && $stable(mem_addr)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R9
  done_no_read_chk: assert property (@(posedge clk) disable iff (rst) done |-> !mem_rd);

  // R10
  pc_inc_chk: assert property (@(posedge clk) disable iff (rst) done |-> (pc_inc == INCW'(2)));

  // R3
  imm_with_done_chk: assert property (@(posedge clk) disable iff (rst) is_imm |-> done);
endmodule

bind amode_seq amode_seq_chk #(.W(W), .INCW(INCW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wait (mem_wait),
  .done     (done),
  .is_imm   (is_imm),
  .pc_inc   (pc_inc)
);

// File: tb/sim_amode_seq.sv
module sim_amode_seq;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  pc_in = '0, opcode = '0, idx_x = '0, idx_y = '0;
  logic [W-1:0]  mem_addr, mem_rdata = '0, result;
  logic          mem_rd, mem_wait = 1'b0, done, is_imm;
  logic [2:0]    pc_inc;

  int n_run = 0, n_fail = 0;
  logic          wait_en = 1'b0;
  logic [15:0]   lfsr = 16'hACE1;
  logic [W-1:0]  rd_log [4];
  int            rd_n = 0;

  always #2 clk = ~clk;

  amode_seq u0 (
    .clk(clk), .rst(rst), .start(start), .pc_in(pc_in), .opcode(opcode),
    .idx_x(idx_x), .idx_y(idx_y), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_wait(mem_wait), .done(done), .result(result),
    .is_imm(is_imm), .pc_inc(pc_inc)
  );

  function automatic logic [W-1:0] memf(logic [W-1:0] a);
    logic [31:0] p;
    p = {16'h0, a} * 32'h9E37;
    return p[15:0] ^ {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  always @(posedge clk) begin
    if (mem_rd && !mem_wait) begin
      mem_rdata <= memf(mem_addr);
      if (rd_n < 4) rd_log[rd_n] = mem_addr;
      rd_n = rd_n + 1;
    end
  end

  always @(negedge clk) begin
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_wait <= wait_en & lfsr[0] & lfsr[3];
  end

  initial begin
    #400000;
    n_fail = n_fail + 1;
    $display("FAIL watchdog: run hung (actual timeout, expected finish)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run = n_run + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [2:0] m, input logic [W-1:0] pc,
                         input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic poke);
    logic [W-1:0] op, ptr_a, ptr, exp_r;
    int lat, extra;
    logic indir;
    op    = memf(pc + 16'd1);
    indir = m[2];
    ptr_a = op + ((m == 3'd5 || m == 3'd7) ? x : 16'h0);
    ptr   = memf(ptr_a);
    case (m)
      3'd0, 3'd1: exp_r = op;
      3'd2:       exp_r = op + x;
      3'd3:       exp_r = op + y;
      3'd4, 3'd5: exp_r = ptr;
      default:    exp_r = ptr + y;
    endcase
    @(negedge clk);
    rd_n = 0;
    pc_in = pc; opcode = {13'h1AB, m}; idx_x = x; idx_y = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done && lat < 200) begin
      if (poke && lat == 2) begin
        start = 1'b1; opcode = {13'h0, ~m}; pc_in = ~pc; idx_x = ~x; idx_y = ~y;
      end
      @(negedge clk);
      start = 1'b0;
      lat = lat + 1;
    end
    case (m)
      3'd0:        chk("R3 result", result, exp_r);
      3'd1, 3'd2, 3'd3: chk("R4 result", result, exp_r);
      3'd4, 3'd5:  chk("R5 result", result, exp_r);
      3'd6:        chk("R6 result", result, exp_r);
      default:     chk("R7 result", result, exp_r);
    endcase
    chk("R3 is_imm", {15'h0, is_imm}, {15'h0, (m == 3'd0)});
    chk("R10 pc_inc", {13'h0, pc_inc}, 16'd2);
    chk("R2 first read addr", rd_log[0], pc + 16'd1);
    chk(indir ? "R5 read count" : "R4 read count", 16'(rd_n), indir ? 16'd2 : 16'd1);
    if (indir) chk(m == 3'd6 ? "R6 ptr addr" : "R7 ptr addr", rd_log[1], ptr_a);
    if (!wait_en) chk("R9 latency", 16'(lat), indir ? 16'd5 : 16'd3);
    extra = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done) extra = extra + 1;
    end
    chk(poke ? "R11 no second done" : "R9 single done", 16'(extra), 16'd0);
  endtask

  initial begin
    logic [W-1:0] xs [4];
    logic [W-1:0] pcs [3];
    xs[0] = 16'h0000; xs[1] = 16'h0001; xs[2] = 16'hFFFF; xs[3] = 16'h8123;
    pcs[0] = 16'h0100; pcs[1] = 16'hFFFF; pcs[2] = 16'h7FFE;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {15'h0, done}, 16'h0);
    chk("R1 mem_rd in reset", {15'h0, mem_rd}, 16'h0);
    chk("R1 is_imm in reset", {15'h0, is_imm}, 16'h0);
    rst = 1'b0;
    for (int we = 0; we < 2; we++) begin
      wait_en = (we == 1);
      for (int m = 0; m < 8; m++)
        for (int p = 0; p < 3; p++)
          for (int i = 0; i < 4; i++)
            run_one(3'(m), pcs[p], xs[i], xs[3 - i] ^ 16'h0F0F, 1'b0);
    end
    wait_en = 1'b1;
    for (int m = 0; m < 8; m++) run_one(3'(m), 16'h2222, 16'h0040, 16'hFFF0, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule